// File: doc/BRIEF.md
# Composite Memory Select Combiner

This block builds one extra chip-select output, the composite select, from the four internal active-low memory selects: program, data, byte and I/O. An enable register holds one bit per select. The composite output is low whenever any select whose enable bit is set is low. The path from selects to output is purely combinational, so the composite output has the same timing as the selects it follows.

The block also gates the external byte select pin with a disable control. A typical use is to boot from a memory on the byte select. Software then sets the disable control and enables the byte bit in the composite register, so that a second memory on the composite pin takes over the byte space. While the memory strobes are three-stated, the disable has no effect, and both output pins report high impedance by driving their output enables low.

Top module: `cms_combiner`

## Requirements
- R1: After reset the enable register is 4'b1011, with bit order [0] program, [1] data, [2] byte and [3] I/O. The program, data and I/O selects drive the composite output, and the byte select does not.
- R2: `comp_n_o` is low in the same cycle that any select with a set enable bit is low (`sel_n_i` bit order as in R1). It is high when no enabled select is low.
- R3: A select whose enable bit is 0 has no effect on `comp_n_o`.
- R4: A write with `en_we_i` high loads `en_wdata_i` at the clock edge. The new enables govern `comp_n_o` from that edge on, and the old enables govern it before the edge.
- R5: With `bsel_dis_i` low, `bsel_n_o` equals `sel_n_i[2]`.
- R6: With `bsel_dis_i` high and `tristate_i` low, `bsel_n_o` is held high whatever the byte select does.
- R7: With `tristate_i` high, `bsel_n_o` equals `sel_n_i[2]` regardless of `bsel_dis_i`.
- R8: `comp_oe_o` and `bsel_oe_o` are low while `tristate_i` is high, and high otherwise.
- R9: With `en_we_i` low, `en_wdata_i` is ignored and the enable register keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_n_i | input | 4 | Internal selects, active low: [0] program, [1] data, [2] byte, [3] I/O |
| tristate_i | input | 1 | Memory strobes are three-stated |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | Enable register write data |
| bsel_dis_i | input | 1 | Byte select pin disable |
| bsel_n_o | output | 1 | External byte select, active low |
| bsel_oe_o | output | 1 | Output enable for the byte select pin |
| comp_n_o | output | 1 | Composite select, active low |
| comp_oe_o | output | 1 | Output enable for the composite pin |

## Verification
Two events can fall in the same cycle. A byte access can be suppressed on its own pin while it is routed onto the composite pin, and the bus can be three-stated while the disable is set. The bench provokes both by sweeping every enable value, every select pattern, and both values of the disable and three-state inputs together. For each case it checks both pins and both output enables against values computed from the requirements. Enable writes are judged on both sides of the loading edge, so a one-cycle slip in the register shows up as a mismatch.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int unsigned NUM_SEL = 4;
  typedef enum logic [1:0] {
    SEL_PROG = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BYTE = 2'd2,
    SEL_IO   = 2'd3
  } sel_idx_e;
  localparam logic [NUM_SEL-1:0] EN_RST = 4'b1011;
endpackage

// File: rtl/cms_en_reg.sv
module cms_en_reg #(
  parameter int unsigned       W       = 4,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/cms_or.sv
module cms_or #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] sel_n_i,
  input  logic [W-1:0] en_i,
  output logic         comp_n_o
);
  logic [W-1:0] hit;
  for (genvar g = 0; g < W; g++) begin : g_hit
    assign hit[g] = en_i[g] & ~sel_n_i[g];
  end
  assign comp_n_o = ~|hit;
endmodule

// File: rtl/cms_bsel_gate.sv
module cms_bsel_gate (
  input  logic bsel_n_i,
  input  logic dis_i,
  input  logic tristate_i,
  output logic bsel_n_o
);
  // suppression only while strobes are actively driven
  always_comb begin
    if (dis_i && !tristate_i) bsel_n_o = 1'b1;
    else                      bsel_n_o = bsel_n_i;
  end
endmodule

// File: rtl/cms_combiner.sv
module cms_combiner
  import cms_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SEL-1:0] sel_n_i,
  input  logic               tristate_i,
  input  logic               en_we_i,
  input  logic [NUM_SEL-1:0] en_wdata_i,
  input  logic               bsel_dis_i,
  output logic               bsel_n_o,
  output logic               bsel_oe_o,
  output logic               comp_n_o,
  output logic               comp_oe_o
);
  logic [NUM_SEL-1:0] en_q;

  cms_en_reg #(.W(NUM_SEL), .RST_VAL(EN_RST)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .q_o     (en_q)
  );

  cms_or #(.W(NUM_SEL)) u_or (
    .sel_n_i  (sel_n_i),
    .en_i     (en_q),
    .comp_n_o (comp_n_o)
  );

  cms_bsel_gate u_bsel (
    .bsel_n_i   (sel_n_i[SEL_BYTE]),
    .dis_i      (bsel_dis_i),
    .tristate_i (tristate_i),
    .bsel_n_o   (bsel_n_o)
  );

  assign bsel_oe_o = ~tristate_i;
  assign comp_oe_o = ~tristate_i;
endmodule

// File: rtl/cms_combiner_chk.sv
module cms_combiner_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] sel_n_i,
  input logic       tristate_i,
  input logic       bsel_dis_i,
  input logic       bsel_n_o,
  input logic       bsel_oe_o,
  input logic       comp_n_o,
  input logic       comp_oe_o
);
  AST_IDLE_COMP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&sel_n_i) |-> comp_n_o); // R2
  AST_BSEL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bsel_dis_i |-> (bsel_n_o == sel_n_i[2])); // R5
  AST_BSEL_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsel_dis_i && !tristate_i) |-> bsel_n_o); // R6
  AST_TRI_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tristate_i |-> (bsel_n_o == sel_n_i[2])); // R7
  AST_TRI_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_oe_o == !tristate_i) && (bsel_oe_o == !tristate_i)); // R8
endmodule

bind cms_combiner cms_combiner_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_n_i    (sel_n_i),
  .tristate_i (tristate_i),
  .bsel_dis_i (bsel_dis_i),
  .bsel_n_o   (bsel_n_o),
  .bsel_oe_o  (bsel_oe_o),
  .comp_n_o   (comp_n_o),
  .comp_oe_o  (comp_oe_o)
);

// File: tb/tb_cms_combiner.sv
module tb_cms_combiner;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel_n_i = 4'hF;
  logic       tristate_i = 1'b0;
  logic       en_we_i = 1'b0;
  logic [3:0] en_wdata_i = 4'h0;
  logic       bsel_dis_i = 1'b0;
  logic       bsel_n_o, bsel_oe_o, comp_n_o, comp_oe_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] en_model;

  always #10 clk_i = ~clk_i;

  cms_combiner dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b sel=%b en=%b dis=%b tri=%b",
               req, act, exp, sel_n_i, en_model, bsel_dis_i, tristate_i);
    end
  endtask

  function automatic logic comp_exp(input logic [3:0] s, input logic [3:0] e);
    return ((~s & e) == 4'b0000);
  endfunction

  // full sweep of select, disable and three-state for the current enables
  task automatic sweep(input string req);
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        @(negedge clk_i);
        sel_n_i = 4'(s); bsel_dis_i = m[0]; tristate_i = m[1];
        #1;
        chk(req, comp_n_o, comp_exp(4'(s), en_model));
        chk(m[1] ? "R8" : "R8", comp_oe_o, !m[1]);
        chk("R8", bsel_oe_o, !m[1]);
        if (m[1])      chk("R7", bsel_n_o, s[2]);
        else if (m[0]) chk("R6", bsel_n_o, 1'b1);
        else           chk("R5", bsel_n_o, s[2]);
      end
    end
  endtask

  task automatic write_en(input logic [3:0] v);
    @(negedge clk_i);
    en_we_i = 1'b1; en_wdata_i = v; sel_n_i = ~v;
    #1;
    if (v != en_model) chk("R4", comp_n_o, comp_exp(~v, en_model)); // before edge: old
    @(posedge clk_i); #1;
    en_model = v;
    chk("R4", comp_n_o, comp_exp(~v, en_model)); // after edge: new
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    en_model = 4'b1011;
    #35 rst_ni = 1'b1;
    // R1: reset enables; byte select alone must not reach composite
    @(negedge clk_i); sel_n_i = 4'b1011; #1;
    chk("R1", comp_n_o, 1'b1);
    sel_n_i = 4'b0111; #1; chk("R1", comp_n_o, 1'b0);
    sweep("R1");
    // R9: data ignored without write strobe
    @(negedge clk_i); en_wdata_i = 4'b0000; en_we_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); sel_n_i = 4'b0000; #1;
    chk("R9", comp_n_o, 1'b0);
    sel_n_i = 4'b1011; #1; chk("R9", comp_n_o, 1'b1);
    // R2/R3/R4: every enable value
    for (int e = 0; e < 16; e++) begin
      write_en(4'(e ^ 5));
      sweep(((e & 1) != 0) ? "R3" : "R2");
    end
    // R9 after a changed value
    @(negedge clk_i); en_wdata_i = ~en_model;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); sel_n_i = ~en_model; #1;
    chk("R9", comp_n_o, comp_exp(~en_model, en_model));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule